// File: doc/BRIEF.md
# Tagged Custom-Operation Dispatch Unit

This unit sits next to a processor register file and holds a small set of custom operations, one per row. Each row is configured with an identifying tag, up to four source register numbers and an operation code. Rows read live copies of the register file all the time and compute their results in combinational logic, so a row's work begins as soon as its operands land in the register file. No row keeps state from one operation to the next.

When the pipeline issues a custom-operation instruction, its tag is compared against every enabled row. If a row matches, the unit stalls the pipeline until that row's operands have been valid and undisturbed for a fixed settle time, and then drives the row's result onto the writeback bus. If no row matches, the unit raises a miss together with the stall and holds both until an external agent pulses load-done. Loading row configurations and the pipeline itself are outside this block. Row configuration arrives on static input ports.

Top module: `custom_op_unit`

## Requirements
- R1: A row's result depends on its operation code and its enabled source values: 0 gives the wrapping sum of the sources, 1 their XOR, 2 the bit-reversed XOR, and 3 the sum with its upper and lower halves swapped. A row may use as many as four sources.
- R2: A row becomes ready only after every enabled source has been valid, with no write to it, for SETTLE (default 2) full clock cycles. After a write to a source in cycle t, the row is ready in cycle t+SETTLE+1 at the earliest.
- R3: While an issued tag matches a row that is not ready, stall is 1 and wb_valid is 0.
- R4: While an issued tag matches a ready row and no miss is pending, wb_valid is 1, stall is 0, and wb_data carries that row's result in the same cycle.
- R5: When several enabled rows carry the issued tag, the row with the lowest index supplies the result.
- R6: An issued tag that matches no enabled row raises miss and stall in the same cycle. Both stay high, whether or not issue continues, until the cycle after a load_done pulse.
- R7: A row whose enable bit is 0 never matches a tag.
- R8: A write to a register, or loss of validity on a register, that is not one of a row's enabled sources has no effect on that row's readiness.
- R9: After reset, with no issue, stall, miss and wb_valid are 0 and wb_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rf_data | input | NREG*DATA_W | Live copy of all register values, register i at bits i*DATA_W |
| rf_valid | input | NREG | Per-register valid flag (0 while a write is pending) |
| rf_wr_en | input | 1 | A register write lands this cycle |
| rf_wr_idx | input | IDX_W | Register number of that write |
| cfg_row_en | input | ROWS | Row enable bits |
| cfg_tag | input | ROWS*TAG_W | Per-row operation tag |
| cfg_src_idx | input | ROWS*SRC_MAX*IDX_W | Per-row, per-slot source register numbers |
| cfg_src_en | input | ROWS*SRC_MAX | Per-row, per-slot source enables |
| cfg_op | input | ROWS*2 | Per-row operation code |
| iss_valid | input | 1 | A custom-operation instruction is issuing |
| iss_tag | input | TAG_W | Tag of the issuing instruction |
| load_done | input | 1 | Pulse that ends a pending miss |
| stall | output | 1 | Hold the pipeline |
| miss | output | 1 | No row holds the requested operation |
| wb_valid | output | 1 | Result is valid on wb_data this cycle |
| wb_data | output | DATA_W | Result of the selected row |

## Verification
If a settle counter is wrong, an issued tag either returns a result in the same cycle as a recent write to one of its sources, or never stops stalling. The cycle-accurate readiness checks after writes and after validity drops expose this within SETTLE+1 cycles. A wrong tag-priority or enable state sends the wrong row's value to wb_data on the first issue, and the sweep alternates between duplicated and disabled rows to catch it. A miss flag that clears too early or too late shows at the miss port in the cycle around load_done.

// File: rtl/cop_pkg.sv
package cop_pkg;
  typedef enum logic [1:0] {
    OP_SUM  = 2'd0,
    OP_XOR  = 2'd1,
    OP_BREV = 2'd2,
    OP_SWAP = 2'd3
  } cop_op_e;
endpackage

// File: rtl/cop_row.sv
module cop_row
  import cop_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NREG    = 8,
  parameter int SRC_MAX = 4,
  parameter int SETTLE  = 2,
  localparam int IDX_W  = $clog2(NREG),
  localparam int CNT_W  = $clog2(SETTLE + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREG*DATA_W-1:0]   rf_data,
  input  logic [NREG-1:0]          rf_valid,
  input  logic                     rf_wr_en,
  input  logic [IDX_W-1:0]         rf_wr_idx,
  input  logic [SRC_MAX*IDX_W-1:0] src_idx,
  input  logic [SRC_MAX-1:0]       src_en,
  input  cop_op_e                  op,
  output logic [DATA_W-1:0]        result,
  output logic                     ready
);

  logic [DATA_W-1:0] rf_arr [NREG];
  logic [DATA_W-1:0] acc_sum, acc_xor, rev_xor;
  logic              touched;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign rf_arr[g] = rf_data[g*DATA_W +: DATA_W];
  end

  // Operand gather and combine
  always_comb begin
    acc_sum = '0;
    acc_xor = '0;
    touched = 1'b0;
    for (int s = 0; s < SRC_MAX; s++) begin
      if (src_en[s]) begin
        acc_sum = acc_sum + rf_arr[src_idx[s*IDX_W +: IDX_W]];
        acc_xor = acc_xor ^ rf_arr[src_idx[s*IDX_W +: IDX_W]];
        if (!rf_valid[src_idx[s*IDX_W +: IDX_W]] ||
            (rf_wr_en && (rf_wr_idx == src_idx[s*IDX_W +: IDX_W])))
          touched = 1'b1;
      end
    end
  end

  always_comb begin
    for (int b = 0; b < DATA_W; b++) rev_xor[b] = acc_xor[DATA_W-1-b];
  end

  always_comb begin
    unique case (op)
      OP_SUM:  result = acc_sum;
      OP_XOR:  result = acc_xor;
      OP_BREV: result = rev_xor;
      OP_SWAP: result = {acc_sum[DATA_W/2-1:0], acc_sum[DATA_W-1:DATA_W/2]};
      default: result = acc_sum;
    endcase
  end

  // Settle counter: reloads on any disturbance, counts down otherwise
  always_comb begin
    if (touched)            cnt_d = CNT_W'(SETTLE);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(SETTLE);
    else        cnt_q <= cnt_d;
  end

  assign ready = !touched && (cnt_q == '0);

  // R2: a disturbed row cannot be ready in the following cycle
  a_r2_touch_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    touched |=> !ready);

  // R2: a ready row stays ready while nothing disturbs it
  a_r2_ready_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !touched) |=> (cnt_q == '0));

endmodule

// File: rtl/cop_select.sv
module cop_select #(
  parameter int ROWS   = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ROWS-1:0]        row_en,
  input  logic [ROWS*TAG_W-1:0]  row_tag,
  input  logic [ROWS*DATA_W-1:0] row_result,
  input  logic [ROWS-1:0]        row_ready,
  input  logic [TAG_W-1:0]       iss_tag,
  output logic                   any_hit,
  output logic                   sel_ready,
  output logic [DATA_W-1:0]      sel_data
);

  logic [ROWS-1:0] match, first;

  for (genvar r = 0; r < ROWS; r++) begin : g_cmp
    assign match[r] = row_en[r] && (row_tag[r*TAG_W +: TAG_W] == iss_tag);
  end

  // Lowest index wins
  always_comb begin
    first = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (match[r]) begin
        first    = '0;
        first[r] = 1'b1;
      end
    end
  end

  always_comb begin
    sel_ready = 1'b0;
    sel_data  = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (first[r]) begin
        sel_ready = row_ready[r];
        sel_data  = row_result[r*DATA_W +: DATA_W];
      end
    end
  end

  assign any_hit = |match;

  // R5: at most one row drives the result
  a_r5_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(first));

  // R7: a disabled row is never chosen
  a_r7_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (first & ~row_en) == '0);

endmodule

// File: rtl/custom_op_unit.sv
module custom_op_unit
  import cop_pkg::*;
#(
  parameter int ROWS    = 4,
  parameter int TAG_W   = 8,
  parameter int DATA_W  = 32,
  parameter int NREG    = 8,
  parameter int SRC_MAX = 4,
  parameter int SETTLE  = 2,
  localparam int IDX_W  = $clog2(NREG)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NREG*DATA_W-1:0]        rf_data,
  input  logic [NREG-1:0]               rf_valid,
  input  logic                          rf_wr_en,
  input  logic [IDX_W-1:0]              rf_wr_idx,
  input  logic [ROWS-1:0]               cfg_row_en,
  input  logic [ROWS*TAG_W-1:0]         cfg_tag,
  input  logic [ROWS*SRC_MAX*IDX_W-1:0] cfg_src_idx,
  input  logic [ROWS*SRC_MAX-1:0]       cfg_src_en,
  input  logic [ROWS*2-1:0]             cfg_op,
  input  logic                          iss_valid,
  input  logic [TAG_W-1:0]              iss_tag,
  input  logic                          load_done,
  output logic                          stall,
  output logic                          miss,
  output logic                          wb_valid,
  output logic [DATA_W-1:0]             wb_data
);

  logic [1:0]             rst_sync;
  logic                   rst_ns;
  logic [ROWS*DATA_W-1:0] row_result;
  logic [ROWS-1:0]        row_ready;
  logic                   any_hit, sel_ready;
  logic [DATA_W-1:0]      sel_data;
  logic                   miss_q, miss_d;

  // Reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    cop_row #(
      .DATA_W (DATA_W),
      .NREG   (NREG),
      .SRC_MAX(SRC_MAX),
      .SETTLE (SETTLE)
    ) u_row (
      .clk      (clk),
      .rst_n    (rst_ns),
      .rf_data  (rf_data),
      .rf_valid (rf_valid),
      .rf_wr_en (rf_wr_en),
      .rf_wr_idx(rf_wr_idx),
      .src_idx  (cfg_src_idx[r*SRC_MAX*IDX_W +: SRC_MAX*IDX_W]),
      .src_en   (cfg_src_en[r*SRC_MAX +: SRC_MAX]),
      .op       (cop_op_e'(cfg_op[r*2 +: 2])),
      .result   (row_result[r*DATA_W +: DATA_W]),
      .ready    (row_ready[r])
    );
  end

  cop_select #(
    .ROWS  (ROWS),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) u_sel (
    .clk       (clk),
    .rst_n     (rst_ns),
    .row_en    (cfg_row_en),
    .row_tag   (cfg_tag),
    .row_result(row_result),
    .row_ready (row_ready),
    .iss_tag   (iss_tag),
    .any_hit   (any_hit),
    .sel_ready (sel_ready),
    .sel_data  (sel_data)
  );

  // Miss tracking
  always_comb begin
    miss   = miss_q || (iss_valid && !any_hit);
    miss_d = miss && !load_done;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) miss_q <= 1'b0;
    else         miss_q <= miss_d;
  end

  always_comb begin
    stall    = miss || (iss_valid && !sel_ready);
    wb_valid = iss_valid && !stall;
    wb_data  = wb_valid ? sel_data : '0;
  end

  // R6: a miss always stalls
  a_r6_miss_stalls: assert property (@(posedge clk) disable iff (!rst_ns)
    miss |-> stall);

  // R6: miss persists until load_done
  a_r6_miss_held: assert property (@(posedge clk) disable iff (!rst_ns)
    (miss && !load_done) |=> miss);

  // R6: load_done with no new request clears the miss
  a_r6_miss_clears: assert property (@(posedge clk) disable iff (!rst_ns)
    (load_done && !iss_valid) |=> !miss || iss_valid);

  // R3 / R4: an issuing instruction either stalls or writes back
  a_r3_issue_outcome: assert property (@(posedge clk) disable iff (!rst_ns)
    iss_valid |-> (stall != wb_valid));

endmodule

// File: tb/custom_op_unit_test.sv
module custom_op_unit_test;

  localparam int ROWS = 4, TAG_W = 8, DATA_W = 32, NREG = 8, SRC_MAX = 4, SETTLE = 2;
  localparam int IDX_W = 3;

  logic                          clk = 1'b0;
  logic                          rst_n;
  logic [NREG*DATA_W-1:0]        rf_data;
  logic [NREG-1:0]               rf_valid;
  logic                          rf_wr_en;
  logic [IDX_W-1:0]              rf_wr_idx;
  logic [ROWS-1:0]               cfg_row_en;
  logic [ROWS*TAG_W-1:0]         cfg_tag;
  logic [ROWS*SRC_MAX*IDX_W-1:0] cfg_src_idx;
  logic [ROWS*SRC_MAX-1:0]       cfg_src_en;
  logic [ROWS*2-1:0]             cfg_op;
  logic                          iss_valid;
  logic [TAG_W-1:0]              iss_tag;
  logic                          load_done;
  logic                          stall, miss, wb_valid;
  logic [DATA_W-1:0]             wb_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] sh [NREG];

  always #10 clk = ~clk;

  custom_op_unit uut (
    .clk(clk), .rst_n(rst_n), .rf_data(rf_data), .rf_valid(rf_valid),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .cfg_row_en(cfg_row_en),
    .cfg_tag(cfg_tag), .cfg_src_idx(cfg_src_idx), .cfg_src_en(cfg_src_en),
    .cfg_op(cfg_op), .iss_valid(iss_valid), .iss_tag(iss_tag),
    .load_done(load_done), .stall(stall), .miss(miss), .wb_valid(wb_valid),
    .wb_data(wb_data)
  );

  function automatic logic [31:0] brev(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = x[31-i];
    return r;
  endfunction

  function automatic logic [31:0] swp(input logic [31:0] x);
    return {x[15:0], x[31:16]};
  endfunction

  function automatic logic [31:0] pat(input int p, input int i);
    if (p == 1) return 32'hFFFF_FFFF;
    return 32'(p) * 32'h9E37_79B1 + 32'(i) * 32'h7F4A_7C15;
  endfunction

  // Expected results of the four configured rows
  function automatic logic [31:0] exp_row(input int r);
    case (r)
      0:       return sh[0] + sh[1] + sh[2] + sh[3];
      1:       return sh[4] ^ sh[5];
      2:       return brev(sh[6]);
      default: return swp(sh[7] + sh[0]);
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_reg(input int i, input logic [31:0] v);
    sh[i] = v;
    rf_data[i*32 +: 32] = v;
  endtask

  task automatic set_src(input int r, input int s, input int idx);
    cfg_src_idx[(r*SRC_MAX+s)*IDX_W +: IDX_W] = IDX_W'(idx);
    cfg_src_en[r*SRC_MAX+s] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rf_data = '0; rf_valid = '1; rf_wr_en = 1'b0; rf_wr_idx = '0;
    iss_valid = 1'b0; iss_tag = '0; load_done = 1'b0;
    for (int i = 0; i < NREG; i++) put_reg(i, 32'(i) * 32'h0101_0101);
    cfg_row_en  = 4'b1111;
    cfg_tag     = {8'h22, 8'h33, 8'h22, 8'h11};
    cfg_op      = {2'd3, 2'd2, 2'd1, 2'd0};
    cfg_src_idx = '0;
    cfg_src_en  = '0;
    for (int s = 0; s < 4; s++) set_src(0, s, s);
    set_src(1, 0, 4); set_src(1, 1, 5);
    set_src(2, 0, 6);
    set_src(3, 0, 7); set_src(3, 1, 0);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #5;
    chk("R9 stall", 32'(stall), 0);
    chk("R9 miss", 32'(miss), 0);
    chk("R9 wb_valid", 32'(wb_valid), 0);
    chk("R9 wb_data", wb_data, 0);

    // Sweep of data patterns, alternating duplicate-tag priority and disabled row
    for (int p = 0; p < 48; p++) begin
      for (int i = 0; i < NREG; i++) begin
        @(negedge clk);
        rf_wr_en = 1'b1; rf_wr_idx = IDX_W'(i); put_reg(i, pat(p, i));
      end
      @(negedge clk);
      rf_wr_en = 1'b0;
      cfg_row_en[1] = (p % 2 == 0);
      repeat (SETTLE + 1) @(negedge clk);
      iss_valid = 1'b1; iss_tag = 8'h11; #5;
      chk("R1 R4 sum row valid", 32'(wb_valid), 1);
      chk("R1 sum of four sources", wb_data, exp_row(0));
      @(negedge clk); iss_tag = 8'h22; #5;
      chk("R4 stall low", 32'(stall), 0);
      if (p % 2 == 0) chk("R5 lowest row wins", wb_data, exp_row(1));
      else            chk("R7 disabled row skipped", wb_data, exp_row(3));
      @(negedge clk); iss_tag = 8'h33; #5;
      chk("R1 bit-reverse row", wb_data, exp_row(2));
      @(negedge clk); iss_valid = 1'b0;
    end
    cfg_row_en = 4'b1111;

    // Settle timing after a source write, while other rows stay ready
    @(negedge clk);
    rf_wr_en = 1'b1; rf_wr_idx = 3'd5; put_reg(5, 32'hA5A5_0F0F);
    iss_valid = 1'b1; iss_tag = 8'h11; #5;
    chk("R8 unrelated write keeps row ready", 32'(wb_valid), 1);
    chk("R8 unrelated row data", wb_data, exp_row(0));
    @(negedge clk); rf_wr_en = 1'b0; iss_tag = 8'h22;
    for (int k = 0; k <= SETTLE; k++) begin
      #5;
      if (k < SETTLE) begin
        chk("R3 stall while settling", 32'(stall), 1);
        chk("R3 no writeback while settling", 32'(wb_valid), 0);
        chk("R2 no miss while settling", 32'(miss), 0);
      end else begin
        chk("R2 ready after settle", 32'(wb_valid), 1);
        chk("R2 settled result", wb_data, exp_row(1));
      end
      @(negedge clk);
    end

    // Validity drop on a source
    rf_valid[6] = 1'b0; iss_tag = 8'h33;
    for (int k = 0; k < 3; k++) begin
      #5; chk("R3 stall while source invalid", 32'(stall), 1);
      @(negedge clk);
    end
    rf_valid[6] = 1'b1;
    for (int k = 0; k <= SETTLE; k++) begin
      #5;
      if (k < SETTLE) chk("R2 settle after valid", 32'(stall), 1);
      else            chk("R2 result after valid", wb_data, exp_row(2));
      @(negedge clk);
    end

    // Validity drop on an unrelated register
    rf_valid[6] = 1'b0; iss_tag = 8'h11; #5;
    chk("R8 unrelated invalid keeps row ready", 32'(wb_valid), 1);
    @(negedge clk); rf_valid[6] = 1'b1; iss_valid = 1'b0;

    // Miss handling
    @(negedge clk); iss_valid = 1'b1; iss_tag = 8'h55; #5;
    chk("R6 miss raised", 32'(miss), 1);
    chk("R6 stall with miss", 32'(stall), 1);
    @(negedge clk); iss_valid = 1'b0; #5;
    chk("R6 miss held", 32'(miss), 1);
    chk("R6 stall held", 32'(stall), 1);
    @(negedge clk); iss_valid = 1'b1; iss_tag = 8'h11; #5;
    chk("R6 hit blocked while miss pending", 32'(wb_valid), 0);
    @(negedge clk); iss_valid = 1'b0; load_done = 1'b1; #5;
    chk("R6 miss during load_done", 32'(miss), 1);
    @(negedge clk); load_done = 1'b0; #5;
    chk("R6 miss cleared", 32'(miss), 0);
    chk("R6 stall cleared", 32'(stall), 0);

    // All rows with the tag disabled gives a miss
    @(negedge clk); cfg_row_en = 4'b0101; iss_valid = 1'b1; iss_tag = 8'h22; #5;
    chk("R7 disabled rows miss", 32'(miss), 1);
    @(negedge clk); iss_valid = 1'b0; load_done = 1'b1;
    @(negedge clk); load_done = 1'b0; #5;
    chk("R6 cleared after second load", 32'(miss), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule